// File: doc/BRIEF.md
# System Control Register Sequencer

This block is a 32-bit control register that software reaches through four byte lanes. Each lane has its own write strobe, and the stored word is always visible on the read bus. Some bits are plain storage. Others drive steady control outputs such as ROM overlay, LED, coprocessor memory enable, coprocessor interrupt level and timer priority. Two soft-interrupt bits drive interrupt request lines directly.

A write is compared against the value it replaces, in the same cycle. Those comparisons produce one-cycle event pulses:
- a coprocessor reset pulse;
- a coprocessor start pulse, which carries a 2-bit boot mode;
- a shift strobe for a bit-banged serial device;
- a reset strobe for the serial interface.

Software clocks the serial device one bit at a time. On each falling edge of the software-driven serial clock, the written data bit goes out. The bit that the device returns in that same cycle replaces the stored data bit, so a later read sees it.

Top module: `sysctl_seq`

## Requirements
- R1: After reset every lane reads 0, except when `strap_turbo` is 1 during reset. Then lane 2 reads 0x10 and lane 3 reads 0x80, so `rd_data` is 0x8010_0000.
- R2: Lane k is `wr_data[8k+7:8k]`. A write with `wr_en[k]` stores that lane only, visible on `rd_data` one cycle later. Lanes without a strobe keep their value, and lane 1 is plain storage.
- R3: `irq_soft1` equals lane 0 bit 0 and `irq_soft2` equals lane 0 bit 1, updating the cycle after the write.
- R4: A lane-0 write that takes bit 7 from 1 to 0 raises `cop_reset_pulse` for exactly one cycle, the cycle after the write.
- R5: A lane-0 write that takes bit 7 from 0 to 1 raises `cop_start_pulse` for one cycle. In that cycle, `cop_boot_mode` becomes the inverse of written bits {4,3}, and it holds that value until the next start.
- R6: A lane-2 write with bit 0 (enable) equal to 1, taking bit 1 (serial clock) from 1 to 0, does three things:
  - it pulses `ser_shift` for one cycle;
  - it sets `ser_tx_bit` to written bit 2 (data) and holds it;
  - it stores `ser_rx_bit`, sampled in the write cycle, into lane 2 bit 2.
- R7: Any lane-2 write with written bit 0 equal to 0 pulses `ser_if_reset` for one cycle.
- R8: The control outputs follow the stored bits:
  - lane 0: bit 6 → `cop_blk_end_ie`, bit 5 → `cop_unpacked`;
  - lane 2: bit 7 → `timer_lvl7`;
  - lane 3: bit 7 → `rom_overlay`, bit 6 → `cop_irq_lvl4`, bit 5 → `cop_mem_en`, bit 0 → `led`.
- R9: No pulse appears without a write to its lane. Rewriting an unchanged value gives no reset or start pulse, and every pulse falls after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_turbo | input | 1 | Configuration strap selecting the alternate reset value |
| wr_en | input | 4 | Per-lane write strobes |
| wr_data | input | 32 | Write data, lane k in bits 8k+7:8k |
| rd_data | output | 32 | Stored register word |
| irq_soft1 | output | 1 | Soft interrupt request 1 |
| irq_soft2 | output | 1 | Soft interrupt request 2 |
| cop_reset_pulse | output | 1 | One-cycle coprocessor reset |
| cop_start_pulse | output | 1 | One-cycle coprocessor start |
| cop_boot_mode | output | 2 | Boot mode latched at start |
| cop_blk_end_ie | output | 1 | Block-end interrupt enable |
| cop_unpacked | output | 1 | Unpacked transfer mode |
| cop_irq_lvl4 | output | 1 | Coprocessor interrupt at level 4 (else 3) |
| cop_mem_en | output | 1 | Coprocessor memory enable |
| rom_overlay | output | 1 | ROM overlay control |
| led | output | 1 | LED control |
| timer_lvl7 | output | 1 | Timer interrupt raised to level 7 |
| ser_tx_bit | output | 1 | Serial bit sent on the last shift |
| ser_rx_bit | input | 1 | Serial bit returned by the device |
| ser_shift | output | 1 | One-cycle serial shift strobe |
| ser_if_reset | output | 1 | One-cycle serial interface reset |

## Verification
A wrong stored lane shows on `rd_data` and on the control outputs in the cycle after the write that caused it. A stale previous-value comparison shows as a missing or spurious pulse in that same cycle. A wrong serial capture stays in lane 2 bit 2 until the next shift, so the read that follows exposes it. Boot-mode errors are visible from the start pulse onward, because the mode is held.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int REG_W  = LANES * LANE_W;

  // lane 0
  localparam int L0_COP_RST = 7;
  localparam int L0_BLK_IE  = 6;
  localparam int L0_UNPK    = 5;
  localparam int L0_MODE_HI = 4;
  localparam int L0_MODE_LO = 3;
  localparam int L0_SOFT2   = 1;
  localparam int L0_SOFT1   = 0;
  // lane 2
  localparam int L2_TMR7  = 7;
  localparam int L2_SDATA = 2;
  localparam int L2_SCLK  = 1;
  localparam int L2_SEN   = 0;
  // lane 3
  localparam int L3_ROM  = 7;
  localparam int L3_IRQ4 = 6;
  localparam int L3_MEM  = 5;
  localparam int L3_LED  = 0;

  localparam logic [LANE_W-1:0] TURBO_L2 = 8'h10;
  localparam logic [LANE_W-1:0] TURBO_L3 = 8'h80;

  function automatic logic [1:0] boot_mode_f(input logic [LANE_W-1:0] b0);
    return ~{b0[L0_MODE_HI], b0[L0_MODE_LO]};
  endfunction

  function automatic logic [LANE_W-1:0] lane_reset_f(input int lane, input logic turbo);
    if (turbo && lane == 2) return TURBO_L2;
    if (turbo && lane == 3) return TURBO_L3;
    return '0;
  endfunction

  function automatic logic clk_fall_f(input logic [LANE_W-1:0] old_v,
                                      input logic [LANE_W-1:0] new_v);
    return new_v[L2_SEN] && old_v[L2_SCLK] && !new_v[L2_SCLK];
  endfunction
endpackage

// File: rtl/sysctl_lane_reg.sv
module sysctl_lane_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= rst_val;
    else if (wr) q <= d;
  end
endmodule

// File: rtl/sysctl_cop_edges.sv
module sysctl_cop_edges
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [LANE_W-1:0] old_b0,
  input  logic [LANE_W-1:0] new_b0,
  output logic              rst_pulse,
  output logic              start_pulse,
  output logic [1:0]        boot_mode
);
  logic fall_ev, rise_ev;
  assign fall_ev = wr &&  old_b0[L0_COP_RST] && !new_b0[L0_COP_RST];
  assign rise_ev = wr && !old_b0[L0_COP_RST] &&  new_b0[L0_COP_RST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pulse   <= 1'b0;
      start_pulse <= 1'b0;
      boot_mode   <= '0;
    end else begin
      rst_pulse   <= fall_ev;
      start_pulse <= rise_ev;
      if (rise_ev) boot_mode <= boot_mode_f(new_b0);
    end
  end

  p_cop_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr && old_b0[L0_COP_RST] && !new_b0[L0_COP_RST] |=> rst_pulse);
  p_cop_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !old_b0[L0_COP_RST] && new_b0[L0_COP_RST] |=>
      start_pulse && boot_mode == ~$past(new_b0[L0_MODE_HI:L0_MODE_LO]));
  p_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !rst_pulse && !start_pulse);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_pulse && start_pulse));
endmodule

// File: rtl/sysctl_serial.sv
module sysctl_serial
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [LANE_W-1:0] old_b2,
  input  logic [LANE_W-1:0] new_b2,
  input  logic              rx_bit,
  output logic [LANE_W-1:0] next_b2,
  output logic              shift,
  output logic              tx_bit,
  output logic              if_reset
);
  logic shift_ev, ifrst_ev;
  assign shift_ev = wr && clk_fall_f(old_b2, new_b2);
  assign ifrst_ev = wr && !new_b2[L2_SEN];

  always_comb begin
    next_b2 = new_b2;
    if (shift_ev) next_b2[L2_SDATA] = rx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift    <= 1'b0;
      tx_bit   <= 1'b0;
      if_reset <= 1'b0;
    end else begin
      shift    <= shift_ev;
      if_reset <= ifrst_ev;
      if (shift_ev) tx_bit <= new_b2[L2_SDATA];
    end
  end

  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr && new_b2[L2_SEN] && old_b2[L2_SCLK] && !new_b2[L2_SCLK] |=>
      shift && tx_bit == $past(new_b2[L2_SDATA]));
  p_ifrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !new_b2[L2_SEN] |=> if_reset);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !shift && !if_reset);
endmodule

// File: rtl/sysctl_seq.sv
module sysctl_seq
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_turbo,
  input  logic [LANES-1:0] wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_soft1,
  output logic             irq_soft2,
  output logic             cop_reset_pulse,
  output logic             cop_start_pulse,
  output logic [1:0]       cop_boot_mode,
  output logic             cop_blk_end_ie,
  output logic             cop_unpacked,
  output logic             cop_irq_lvl4,
  output logic             cop_mem_en,
  output logic             rom_overlay,
  output logic             led,
  output logic             timer_lvl7,
  output logic             ser_tx_bit,
  input  logic             ser_rx_bit,
  output logic             ser_shift,
  output logic             ser_if_reset
);
  logic [LANE_W-1:0] lane_q [LANES];
  logic [LANE_W-1:0] lane_d [LANES];
  logic [LANE_W-1:0] serial_next;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 2) begin : g_ser
      assign lane_d[k] = serial_next;
    end else begin : g_plain
      assign lane_d[k] = wr_data[k*LANE_W +: LANE_W];
    end
    sysctl_lane_reg #(.W(LANE_W)) i_lane (
      .clk(clk), .rst_n(rst_n), .wr(wr_en[k]), .d(lane_d[k]),
      .rst_val(lane_reset_f(k, strap_turbo)), .q(lane_q[k]));
    assign rd_data[k*LANE_W +: LANE_W] = lane_q[k];
  end

  sysctl_cop_edges i_cop (
    .clk(clk), .rst_n(rst_n), .wr(wr_en[0]),
    .old_b0(lane_q[0]), .new_b0(wr_data[LANE_W-1:0]),
    .rst_pulse(cop_reset_pulse), .start_pulse(cop_start_pulse),
    .boot_mode(cop_boot_mode));

  sysctl_serial i_ser (
    .clk(clk), .rst_n(rst_n), .wr(wr_en[2]),
    .old_b2(lane_q[2]), .new_b2(wr_data[2*LANE_W +: LANE_W]),
    .rx_bit(ser_rx_bit), .next_b2(serial_next), .shift(ser_shift),
    .tx_bit(ser_tx_bit), .if_reset(ser_if_reset));

  assign irq_soft1      = lane_q[0][L0_SOFT1];
  assign irq_soft2      = lane_q[0][L0_SOFT2];
  assign cop_blk_end_ie = lane_q[0][L0_BLK_IE];
  assign cop_unpacked   = lane_q[0][L0_UNPK];
  assign timer_lvl7     = lane_q[2][L2_TMR7];
  assign rom_overlay    = lane_q[3][L3_ROM];
  assign cop_irq_lvl4   = lane_q[3][L3_IRQ4];
  assign cop_mem_en     = lane_q[3][L3_MEM];
  assign led            = lane_q[3][L3_LED];

  p_soft_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> irq_soft1 == $past(wr_data[L0_SOFT1]) &&
                 irq_soft2 == $past(wr_data[L0_SOFT2]));
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[2] && wr_data[2*LANE_W+L2_SEN] && rd_data[2*LANE_W+L2_SCLK] &&
    !wr_data[2*LANE_W+L2_SCLK] |=> rd_data[2*LANE_W+L2_SDATA] == $past(ser_rx_bit));
  p_lane1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en[1] |=> $stable(rd_data[2*LANE_W-1:LANE_W]));
endmodule

// File: tb/test_sysctl_seq.sv
module test_sysctl_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 13;
  // {wr_en[4], wr_data[32], rx[1], exp_rd[32], {rst,start,shift,ifrst}[4], mode[2], tx[1]}
  localparam logic [75:0] TBL [NROW] = '{
    {4'b0001, 32'h0000_0003, 1'b0, 32'h0000_0003, 4'b0000, 2'b00, 1'b0},
    {4'b0001, 32'h0000_0098, 1'b0, 32'h0000_0098, 4'b0100, 2'b00, 1'b0},
    {4'b0001, 32'h0000_0018, 1'b0, 32'h0000_0018, 4'b1000, 2'b00, 1'b0},
    {4'b0001, 32'h0000_0080, 1'b0, 32'h0000_0080, 4'b0100, 2'b11, 1'b0},
    {4'b0001, 32'h0000_0080, 1'b0, 32'h0000_0080, 4'b0000, 2'b11, 1'b0},
    {4'b0010, 32'h0000_AB00, 1'b0, 32'h0000_AB80, 4'b0000, 2'b11, 1'b0},
    {4'b0100, 32'h0003_0000, 1'b0, 32'h0003_AB80, 4'b0000, 2'b11, 1'b0},
    {4'b0100, 32'h0005_0000, 1'b0, 32'h0001_AB80, 4'b0010, 2'b11, 1'b1},
    {4'b0100, 32'h0003_0000, 1'b1, 32'h0003_AB80, 4'b0000, 2'b11, 1'b1},
    {4'b0100, 32'h0001_0000, 1'b1, 32'h0005_AB80, 4'b0010, 2'b11, 1'b0},
    {4'b0100, 32'h0080_0000, 1'b0, 32'h0080_AB80, 4'b0001, 2'b11, 1'b0},
    {4'b1000, 32'hE100_0000, 1'b0, 32'hE180_AB80, 4'b0000, 2'b11, 1'b0},
    {4'b1111, 32'h1234_5678, 1'b0, 32'h1234_5678, 4'b1001, 2'b11, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, strap_turbo = 1'b0, ser_rx_bit = 1'b0;
  logic [3:0] wr_en = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq_soft1, irq_soft2, cop_reset_pulse, cop_start_pulse;
  logic [1:0] cop_boot_mode;
  logic cop_blk_end_ie, cop_unpacked, cop_irq_lvl4, cop_mem_en, rom_overlay;
  logic led, timer_lvl7, ser_tx_bit, ser_shift, ser_if_reset;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_seq i_sysctl_seq (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] ctl_of(input logic [31:0] r);
    return {r[6], r[5], r[23], r[31], r[30], r[29], r[24], r[1], r[0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", rd_data, 32'h0);
    check("R1 reset outputs", {cop_reset_pulse, cop_start_pulse, ser_shift, ser_if_reset, rom_overlay}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      logic [75:0] r;
      r = TBL[i];
      wr_en = r[75:72]; wr_data = r[71:40]; ser_rx_bit = r[39];
      @(negedge clk);
      wr_en = '0;
      check("R2 read back", rd_data, r[38:7]);
      check("R3 soft irq", {irq_soft2, irq_soft1}, {r[8], r[7]});
      check("R8 controls", ctl_of({cop_irq_lvl4 ? 1'b0 : 1'b0, 31'b0}) | {cop_blk_end_ie, cop_unpacked,
            timer_lvl7, rom_overlay, cop_irq_lvl4, cop_mem_en, led, irq_soft2, irq_soft1}, ctl_of(r[38:7]));
      check("R4 reset pulse", cop_reset_pulse, r[6]);
      check("R5 start pulse", cop_start_pulse, r[5]);
      check("R5 boot mode", cop_boot_mode, r[2:1]);
      check("R6 shift strobe", ser_shift, r[4]);
      check("R6 tx bit", ser_tx_bit, r[0]);
      check("R7 interface reset", ser_if_reset, r[3]);
    end
    // directed: start with mode bits 11 -> mode 00, pulse lasts one cycle
    wr_en = 4'b0001; wr_data = 32'h0000_00F8;
    @(negedge clk);
    wr_en = '0;
    check("R5 start directed", {cop_start_pulse, cop_boot_mode}, 3'b100);
    @(negedge clk);
    check("R9 pulse one cycle", {cop_start_pulse, cop_reset_pulse, ser_shift, ser_if_reset}, 0);
    check("R5 mode held", cop_boot_mode, 2'b00);
    // directed: lane 2 write with serial clock rising gives no shift
    wr_en = 4'b0100; wr_data = 32'h0003_0000;
    @(negedge clk);
    wr_en = '0;
    check("R9 no shift on rising clock", ser_shift, 1'b0);
    // directed: turbo strap reset
    strap_turbo = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 turbo reset", rd_data, 32'h8010_0000);
    check("R1 turbo overlay", rom_overlay, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule